// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing engine of a 2048-byte serial memory. It watches raw, oversampled clock and data lines from a two-wire bus on the system clock and finds the start and stop markers. It shifts in the select byte and the byte address and answers each accepted byte by pulling the data line low in the ninth clock. Read data goes out MSB first. The engine drives the data line only through an active-low output enable, so the pad stays open-drain.

The top three bits of the 11-bit memory address travel inside the select byte. The low eight bits come from a separate address byte. One internal counter serves reads and writes and advances after every byte. It supports reads from the current position, random reads (an address-only write followed by a repeated start) and sequential reads that wrap at the top of memory. Incoming write bytes are passed to a write buffer outside this block, which is also told when a stop closes a write. While that buffer reports a program cycle, the engine refuses the select byte, so the master can poll for completion.

Memory reads are combinational: the engine presents `mem_addr` and expects `mem_rdata` for that address in the same cycle.

Top module: `i2c_mem_slave`

## Requirements
- R1: A start marker (data falling while clock is high) aborts whatever is in progress, releases the data line and makes the next eight bits a select byte. A stop marker (data rising while clock is high) releases the line and returns the engine to standby.
- R2: The select byte is taken MSB first. Bits 7..4 must read 1010, bits 3..1 load address bits 10..8, and bit 0 chooses read (1) or write (0). An accepted select byte is acknowledged by a low data line throughout the ninth clock.
- R3: `sda_oe_n` low means the engine pulls the line low. The engine starts pulling only after the clock has gone low, never while it is high.
- R4: A select byte whose upper nibble is not 1010 gets no acknowledge. Every following bit up to the next start is ignored: no acknowledge, no write strobe and no change to the address counter.
- R5: While `busy_i` is high, a select byte gets no acknowledge, and the rest of that transfer is ignored as in R4.
- R6: In a write, the byte after the select byte loads address bits 7..0 and is acknowledged. Each further byte is acknowledged and presented for one cycle on `wr_stb` with `wr_addr` equal to the counter. The counter then advances by one modulo 2048.
- R7: A stop after at least one write data byte gives a one-cycle `wr_commit` pulse. A stop after only the select and address bytes gives none.
- R8: In a read, the byte at the counter is shifted out MSB first, each bit placed on the line after the clock falls. The counter advances after each byte. A read with no address byte uses the counter's low eight bits with the high bits from the select byte.
- R9: An address-only write followed by a repeated start and a read select returns the byte at the address just loaded.
- R10: When the master acknowledges a read byte, the next byte follows. The counter wraps from 7FFh to 000h.
- R11: When the master leaves the ninth bit of a read byte high, the engine releases the line and stays silent through any further clocks until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line, as seen on the wire |
| sda_oe_n | output | 1 | Active-low pull-down enable for the data line |
| busy_i | input | 1 | Program cycle in progress in the write buffer |
| mem_addr | output | 11 | Current address counter, read address of the memory |
| mem_rdata | input | 8 | Byte stored at `mem_addr` |
| wr_stb | output | 1 | One-cycle strobe per received write data byte |
| wr_addr | output | 11 | Address of the strobed write byte |
| wr_data | output | 8 | Strobed write byte |
| wr_commit | output | 1 | One-cycle pulse when a stop closes a write that carried data |

## Verification
The write strobe for a byte and the counter increment that moves past 7FFh happen in the same system cycle. So a write that crosses the top of memory has to emit 7FEh, 7FFh and then 000h while the counter wraps underneath. The bench writes three bytes starting at 7FEh and checks each strobe's address and data against its own queue of expected writes. It then reads four bytes back from 7FEh with a random read, which shows that both the wrapped strobe and the wrapped read pointer land on address zero.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEVSEL,
      ST_ADDR,
      ST_WDATA,
      ST_RDATA
   } eng_state_e;

   localparam int BYTE_W   = 8;
   localparam int ACK_SLOT = BYTE_W + 1;
   localparam int BITCNT_W = 4;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);
   initial assert (STAGES >= 2) else $error("i2c_line_sync: STAGES must be at least 2");

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
         prev_q  <= RST_VAL;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign lvl_o  = chain_q[STAGES-1];
   assign rise_o = chain_q[STAGES-1] & ~prev_q;
   assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/i2c_addr_ctr.sv
module i2c_addr_ctr #(
   parameter int ADDR_W = 11,
   parameter int LO_W   = 8,
   localparam int HI_W  = ADDR_W - LO_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_hi,
   input  logic [HI_W-1:0]   hi_val,
   input  logic              ld_lo,
   input  logic [LO_W-1:0]   lo_val,
   input  logic              inc,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (ld_hi) begin
         ptr_q[ADDR_W-1:LO_W] <= hi_val;
      end else if (ld_lo) begin
         ptr_q[LO_W-1:0] <= lo_val;
      end else if (inc) begin
         ptr_q <= ptr_q + ADDR_W'(1);
      end
   end

   assign addr_o = ptr_q;
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
   import i2c_mem_pkg::*;
#(
   parameter int         ADDR_W      = 11,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] DEV_CODE    = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_n,
   input  logic              busy_i,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_rdata,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              wr_commit
);
   localparam int HI_W = ADDR_W - BYTE_W;
   localparam logic [BITCNT_W-1:0] CNT_BYTE = BITCNT_W'(BYTE_W);
   localparam logic [BITCNT_W-1:0] CNT_ACK  = BITCNT_W'(ACK_SLOT);

   initial assert (HI_W >= 1 && HI_W <= 3)
      else $error("i2c_mem_slave: select byte carries 1 to 3 high address bits");

   // line 0 = clock, line 1 = data
   logic [1:0] raw_in, lvl, rise, fall;
   assign raw_in = {sda_i, scl_i};

   for (genvar g = 0; g < 2; g++) begin : g_line
      i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d_i   (raw_in[g]),
         .lvl_o (lvl[g]),
         .rise_o(rise[g]),
         .fall_o(fall[g])
      );
   end

   logic scl_lvl, scl_rise, scl_fall, sda_lvl;
   logic start_det, stop_det;
   assign scl_lvl   = lvl[0];
   assign scl_rise  = rise[0];
   assign scl_fall  = fall[0];
   assign sda_lvl   = lvl[1];
   assign start_det = scl_lvl & fall[1];
   assign stop_det  = scl_lvl & rise[1];

   eng_state_e          state_q;
   logic [BITCNT_W-1:0] cnt_q;
   logic [7:0]          rx_q, tx_q;
   logic                rw_q, got_data_q, mack_q, oe_n_q;
   logic                stb_q, commit_q;
   logic [ADDR_W-1:0]   wa_q;
   logic [7:0]          wd_q;

   logic byte_edge, ack_edge, dev_ok;
   logic ld_hi, ld_lo, inc;
   logic [ADDR_W-1:0] ptr;

   assign byte_edge = scl_fall && (cnt_q == CNT_BYTE);
   assign ack_edge  = scl_fall && (cnt_q == CNT_ACK);
   assign dev_ok    = (rx_q[7:4] == DEV_CODE) && !busy_i;

   always_comb begin
      ld_hi = 1'b0;
      ld_lo = 1'b0;
      inc   = 1'b0;
      if (!start_det && !stop_det && byte_edge) begin
         case (state_q)
            ST_DEVSEL: ld_hi = dev_ok;
            ST_ADDR:   ld_lo = 1'b1;
            ST_WDATA:  inc   = 1'b1;
            ST_RDATA:  inc   = 1'b1;
            default:   ;
         endcase
      end
   end

   i2c_addr_ctr #(.ADDR_W(ADDR_W), .LO_W(BYTE_W)) i_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .ld_hi (ld_hi),
      .hi_val(rx_q[HI_W:1]),
      .ld_lo (ld_lo),
      .lo_val(rx_q),
      .inc   (inc),
      .addr_o(ptr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         cnt_q      <= '0;
         rx_q       <= '0;
         tx_q       <= '1;
         rw_q       <= 1'b0;
         got_data_q <= 1'b0;
         mack_q     <= 1'b1;
         oe_n_q     <= 1'b1;
         stb_q      <= 1'b0;
         commit_q   <= 1'b0;
         wa_q       <= '0;
         wd_q       <= '0;
      end else begin
         stb_q    <= 1'b0;
         commit_q <= 1'b0;
         if (start_det) begin
            state_q    <= ST_DEVSEL;
            cnt_q      <= '0;
            oe_n_q     <= 1'b1;
            got_data_q <= 1'b0;
         end else if (stop_det) begin
            state_q  <= ST_IDLE;
            oe_n_q   <= 1'b1;
            commit_q <= (state_q == ST_WDATA) && got_data_q;
         end else if (state_q != ST_IDLE) begin
            if (scl_rise) begin
               if (cnt_q < CNT_BYTE) rx_q <= {rx_q[6:0], sda_lvl};
               if (cnt_q == CNT_BYTE) mack_q <= sda_lvl;
               if (cnt_q < CNT_ACK) cnt_q <= cnt_q + BITCNT_W'(1);
            end else if (byte_edge) begin
               case (state_q)
                  ST_DEVSEL: begin
                     oe_n_q <= !dev_ok;
                     rw_q   <= rx_q[0];
                     if (!dev_ok) state_q <= ST_IDLE;
                  end
                  ST_ADDR:  oe_n_q <= 1'b0;
                  ST_WDATA: begin
                     oe_n_q     <= 1'b0;
                     stb_q      <= 1'b1;
                     wa_q       <= ptr;
                     wd_q       <= rx_q;
                     got_data_q <= 1'b1;
                  end
                  default:  oe_n_q <= 1'b1;
               endcase
            end else if (ack_edge) begin
               cnt_q <= '0;
               if ((state_q == ST_DEVSEL && rw_q) || (state_q == ST_RDATA && !mack_q)) begin
                  state_q <= ST_RDATA;
                  oe_n_q  <= mem_rdata[7];
                  tx_q    <= {mem_rdata[6:0], 1'b1};
               end else begin
                  oe_n_q <= 1'b1;
                  case (state_q)
                     ST_DEVSEL: state_q <= ST_ADDR;
                     ST_ADDR:   state_q <= ST_WDATA;
                     ST_RDATA:  state_q <= ST_IDLE;
                     default:   ;
                  endcase
               end
            end else if (scl_fall && state_q == ST_RDATA) begin
               oe_n_q <= tx_q[7];
               tx_q   <= {tx_q[6:0], 1'b1};
            end
         end
      end
   end

   assign sda_oe_n  = oe_n_q;
   assign mem_addr  = ptr;
   assign wr_stb    = stb_q;
   assign wr_addr   = wa_q;
   assign wr_data   = wd_q;
   assign wr_commit = commit_q;
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_lvl,
   input logic start_det,
   input logic stop_det,
   input logic sda_oe_n,
   input logic wr_stb,
   input logic wr_commit
);
   // R3: pull-down begins only from a low clock
   a_r3_pull_after_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe_n) |-> $past(!scl_lvl));

   // R1: a start marker leaves the line released
   a_r1_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> sda_oe_n);

   // R1: a stop marker leaves the line released
   a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> sda_oe_n);

   // R7: commit only follows a detected stop
   a_r7_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> $past(stop_det));

   // R6: one strobe per byte, never two cycles in a row
   a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);
endmodule

bind i2c_mem_slave i2c_mem_slave_chk i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_lvl  (scl_lvl),
   .start_det(start_det),
   .stop_det (stop_det),
   .sda_oe_n (sda_oe_n),
   .wr_stb   (wr_stb),
   .wr_commit(wr_commit)
);

// File: tb/test_i2c_mem_slave.sv
module test_i2c_mem_slave;
   localparam int AW    = 11;
   localparam int MEM_N = 1 << AW;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
   logic sda_oe_n, wr_stb, wr_commit;
   logic [AW-1:0] mem_addr, wr_addr;
   logic [7:0] mem_rdata, wr_data;
   logic [7:0] mem [MEM_N];
   wire sda_line = sda_m & sda_oe_n;
   assign mem_rdata = mem[mem_addr];

   i2c_mem_slave i_i2c_mem_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe_n(sda_oe_n), .busy_i(busy), .mem_addr(mem_addr),
      .mem_rdata(mem_rdata), .wr_stb(wr_stb), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_commit(wr_commit)
   );

   int vectors = 0, errors = 0, commits = 0, ptr = 0;
   bit done = 0;
   string req = "R3";
   logic chk_en = 1'b0, exp_oe = 1'b1;
   logic [18:0] exp_q[$];
   logic [18:0] pend[$];
   logic [18:0] e;

   // model compared on every clock: line drive, write strobes, commits
   always @(posedge clk) begin
      #3;
      if (chk_en) begin
         vectors++;
         if (sda_oe_n !== exp_oe) begin
            errors++;
            $display("FAIL %s sda_oe_n actual=%b expected=%b at %0t", req, sda_oe_n, exp_oe, $time);
         end
      end
      if (wr_stb === 1'b1) begin
         vectors++;
         pend.push_back({wr_addr, wr_data});
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL %s wr_stb actual=%h/%h expected=none", req, wr_addr, wr_data);
         end else begin
            e = exp_q.pop_front();
            if ({wr_addr, wr_data} !== e) begin
               errors++;
               $display("FAIL R6 wr_stb actual=%h/%h expected=%h/%h", wr_addr, wr_data, e[18:8], e[7:0]);
            end
         end
      end
      if (wr_commit === 1'b1) begin
         commits++;
         foreach (pend[i]) mem[pend[i][18:8]] = pend[i][7:0];
         pend.delete();
      end
   end

   task automatic hw(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string r, input string what, input longint act, input longint exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
      end
   endtask

   task automatic put_bit(input logic b, input logic ex);
      chk_en = 0; hw(2); sda_m = b; hw(4);
      exp_oe = ex; chk_en = 1; hw(2); scl_m = 1; hw(8);
      chk_en = 0; scl_m = 0;
   endtask

   task automatic do_start();
      chk_en = 0; hw(2); sda_m = 1; hw(2); scl_m = 1;
      exp_oe = 1; chk_en = 1; hw(6); sda_m = 0; hw(6);
      chk_en = 0; scl_m = 0;
   endtask

   task automatic do_stop();
      chk_en = 0; hw(2); sda_m = 0; hw(4); scl_m = 1;
      exp_oe = 1; chk_en = 1; hw(6); sda_m = 1; hw(6);
      chk_en = 0; hw(4);
   endtask

   task automatic send_byte(input logic [7:0] b, input logic ack);
      for (int i = 7; i >= 0; i--) put_bit(b[i], 1'b1);
      put_bit(1'b1, !ack);
   endtask

   task automatic recv_byte(input logic [7:0] ex, input logic mack);
      for (int i = 7; i >= 0; i--) put_bit(1'b1, ex[i]);
      put_bit(!mack, 1'b1);
   endtask

   function automatic logic [7:0] dsel(input int hi, input logic rd);
      return {4'b1010, 3'(hi), rd};
   endfunction

   task automatic rd_txn(input int hi, input int n);
      send_byte(dsel(hi, 1'b1), 1'b1);
      ptr = ((hi & 7) << 8) | (ptr & 255);
      for (int k = 0; k < n; k++) begin
         recv_byte(mem[ptr], k != n - 1);
         ptr = (ptr + 1) % MEM_N;
      end
      do_stop();
   endtask

   task automatic rnd_read(input int a, input int n);
      do_start();
      send_byte(dsel(a >> 8, 1'b0), 1'b1);
      send_byte(8'(a), 1'b1);
      ptr = a;
      do_start();
      rd_txn(a >> 8, n);
   endtask

   task automatic wr_txn(input int a, input int n, input int seed);
      int c0;
      logic [7:0] d;
      c0 = commits;
      do_start();
      send_byte(dsel(a >> 8, 1'b0), 1'b1);
      send_byte(8'(a), 1'b1);
      for (int k = 0; k < n; k++) begin
         d = 8'(seed * 29 + k * 71 + 5);
         exp_q.push_back({11'((a + k) % MEM_N), d});
         send_byte(d, 1'b1);
      end
      do_stop();
      ptr = (a + n) % MEM_N;
      chk(req, "strobes left", exp_q.size(), 0);
      chk("R7", "commit count", commits - c0, (n > 0) ? 1 : 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      int c0;
      for (int i = 0; i < MEM_N; i++) mem[i] = 8'(i * 37 + 11);
      hw(4); rst_n = 1; hw(4);

      // R3: released out of reset, no write activity
      chk("R3", "reset sda_oe_n", sda_oe_n, 1);
      chk("R6", "reset wr_stb", wr_stb, 0);
      chk("R7", "reset wr_commit", wr_commit, 0);
      scl_m = 1; sda_m = 1; hw(4);

      req = "R6"; wr_txn(12'h123, 4, 1);
      req = "R9"; rnd_read(12'h123, 3);
      req = "R8"; do_start(); rd_txn(1, 2);

      req = "R7"; wr_txn(12'h2A0, 0, 0);

      // R4: foreign code, then a byte that would be an address
      req = "R4";
      do_start();
      send_byte({4'b1011, 3'd5, 1'b0}, 1'b0);
      send_byte(8'h55, 1'b0);
      do_stop();
      chk("R4", "strobes after foreign code", pend.size() + exp_q.size(), 0);
      req = "R2"; do_start(); rd_txn(3, 1);

      // R5: polled while busy, then accepted once idle
      req = "R5";
      c0 = commits;
      busy = 1;
      do_start();
      send_byte(dsel(1, 1'b0), 1'b0);
      send_byte(8'h10, 1'b0);
      do_stop();
      busy = 0;
      chk("R5", "commit while busy", commits - c0, 0);
      do_start();
      send_byte(dsel(1, 1'b0), 1'b1);
      ptr = (1 << 8) | (ptr & 255);
      do_stop();
      req = "R8"; do_start(); rd_txn(1, 1);

      // R10: write and read across the top of memory
      req = "R10"; wr_txn(12'h7FE, 3, 7);
      chk("R10", "wrapped byte at 000", mem[0], 8'(7 * 29 + 2 * 71 + 5));
      rnd_read(12'h7FE, 4);

      // R11: master declines, further clocks get no drive
      req = "R11";
      do_start();
      send_byte(dsel(0, 1'b1), 1'b1);
      ptr = ptr & 255;
      recv_byte(mem[ptr], 1'b0);
      ptr = (ptr + 1) % MEM_N;
      send_byte(8'h00, 1'b0);
      do_stop();

      // R1: start in the middle of a select byte restarts framing
      req = "R1";
      do_start();
      put_bit(1'b1, 1'b1); put_bit(1'b0, 1'b1); put_bit(1'b1, 1'b1); put_bit(1'b0, 1'b1);
      do_start();
      rd_txn(2, 2);

      chk("R6", "pending expected strobes", exp_q.size(), 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule